// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs the processor side of one coprocessor instruction. After a start pulse it presents a first-cycle request to the coprocessor and follows the coprocessor's per-cycle answer. An answer of busy costs one internal idle cycle, after which a pending interrupt abandons the instruction. A refusal raises a trap. An acceptance completes a register transfer, a data operation, or a multi-word load/store burst.

In a load/store burst the coprocessor sets the length. Each cycle moves one word between the memory port and the coprocessor port. While the coprocessor answers increment, the word address advances by 4. The instruction always ends with a single-cycle done pulse, and the outcome flags are valid in that cycle. The outcome flags and the read result hold their values until the next start.

Top module: `cp_seq`

## Requirements
- R1: After reset, busy_o, done_o, wb_o, mem_req_o and all outcome flags are 0, and cp_phase_o is 0 (idle).
- R2: A start pulse with a legal request leads, one cycle later, to cp_phase_o = 1 (first request). Operation codes on op_i are 0 write-to-coprocessor, 1 read-from-coprocessor, 2 data operation, 3 load, 4 store. Response codes on cp_resp_i are 0 busy, 1 refuse, 2 done, 3 increment. Phase codes are 0 idle, 1 first, 2 busy poll, 3 interrupt notice, 4 register transfer, 5 burst data.
- R3: Every busy answer is followed by one cycle with phase 0. If no interrupt is pending in that cycle, the next cycle polls again with phase 2. With B busy answers, the accepting or refusing answer comes 2*B cycles after the first request.
- R4: If int_pend_i is high in the idle cycle that follows a busy answer, the block shows phase 3 for exactly one cycle and then ends with only intr_o set. No transfer takes place. The done pulse comes 2*k+2 cycles after start, where k is the busy answer that was interrupted.
- R5: A refusal of a write, read or data operation ends the instruction with only undef_o set, one cycle after the refusing answer.
- R6: A refusal of a load or store ends the instruction with only cp_abort_o set.
- R7: After a refused read, rd_data_o equals the flag-only word 32'hF000_0000.
- R8: An accepted write takes one phase-4 cycle that shows src_i on cp_wdata_o. An accepted read takes one phase-4 cycle that captures cp_rdata_i into rd_data_o, plus one internal cycle. An accepted data operation ends at once. The done pulse lasts exactly one cycle.
- R9: Before any coprocessor request, a load or store whose address is at or above MEM_TOP (0xF000) ends one cycle after start with only data_abort_o set. A store whose address is below VEC_TOP (0x0020) ends the same way. A load below VEC_TOP is legal.
- R10: Each burst cycle shows phase 5 and mem_req_o, with mem_addr_o equal to the start address plus 4 per earlier word. A load forwards mem_rdata_i to cp_wdata_o. A store writes cp_rdata_i with mem_we_o set. While the answer is increment the burst continues, and any other answer ends it.
- R11: wb_o is high in the first burst cycle exactly when wb_i was set at start.
- R12: A memory abort in any burst cycle is held and reported as data_abort_o when the burst ends. The burst length does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken while idle |
| op_i | input | 3 | Operation code |
| addr_i | input | AW | Start word address for load/store |
| wb_i | input | 1 | Base writeback request |
| src_i | input | DW | Source word for write-to-coprocessor |
| int_pend_i | input | 1 | Interrupt pending |
| cp_resp_i | input | 2 | Coprocessor answer for the current phase |
| cp_rdata_i | input | DW | Word from the coprocessor |
| cp_phase_o | output | 3 | Phase shown to the coprocessor |
| cp_wdata_o | output | DW | Word to the coprocessor |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, same cycle |
| mem_abort_i | input | 1 | Memory abort for this access |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle end pulse |
| undef_o | output | 1 | Undefined-instruction trap |
| cp_abort_o | output | 1 | Coprocessor abort |
| data_abort_o | output | 1 | Address or memory abort |
| intr_o | output | 1 | Abandoned for an interrupt |
| wb_o | output | 1 | Base writeback pulse |
| rd_data_o | output | DW | Result of a read from the coprocessor |

## Verification
The bench sweeps every operation against 0 to 3 busy answers, a refusal or an acceptance, and an interrupt arriving after each possible busy answer. It predicts the done cycle arithmetically. A sequencer that skipped the idle cycle or polled with the wrong phase would end early. One that checked interrupts at the wrong time would transfer data or never show the interrupt notice. Bursts of 1 to 4 words are run with and without writeback, and with a memory abort on the first or last word. An address counter that steps wrongly, a lost abort, or a writeback pulse on a later word each shows up as a wrong address, flag or pulse. Illegal addresses, a store to the vector region, and a legal load there check that the address screen trips only when it should. They also check that a refused read returns the flag-only word.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;
  typedef enum logic [1:0] {
    RSP_BUSY   = 2'd0,
    RSP_REFUSE = 2'd1,
    RSP_DONE   = 2'd2,
    RSP_INC    = 2'd3
  } cp_rsp_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FIRST = 3'd1,
    PH_BUSY  = 3'd2,
    PH_INTR  = 3'd3,
    PH_XFER  = 3'd4,
    PH_DATA  = 3'd5
  } cp_ph_e;

  typedef enum logic [2:0] {
    OP_WR = 3'd0,
    OP_RD = 3'd1,
    OP_DP = 3'd2,
    OP_LD = 3'd3,
    OP_ST = 3'd4
  } cp_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ASK, S_IWAIT, S_INTR, S_CXFER, S_ICYC, S_BURST, S_FIN
  } seq_st_e;
endpackage

// File: rtl/cp_addr_chk.sv
module cp_addr_chk #(
  parameter int          AW      = 16,
  parameter int unsigned MEM_TOP = 'hF000,
  parameter int unsigned VEC_TOP = 'h0020
) (
  input  logic [AW-1:0] addr_i,
  input  logic          is_store_i,
  output logic          bad_o
);
  localparam logic [AW-1:0] TOP_A = AW'(MEM_TOP);
  localparam logic [AW-1:0] VEC_A = AW'(VEC_TOP);

  always_comb begin
    bad_o = (addr_i >= TOP_A) || (is_store_i && (addr_i < VEC_A));
  end
endmodule

// File: rtl/cp_burst_unit.sv
module cp_burst_unit #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          abort_i,
  output logic [AW-1:0] addr_o,
  output logic          first_o,
  output logic          abort_seen_o
);
  localparam logic [AW-1:0] STEP = AW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o       <= '0;
      first_o      <= 1'b0;
      abort_seen_o <= 1'b0;
    end else if (load_i) begin
      addr_o       <= base_i;
      first_o      <= 1'b1;
      abort_seen_o <= 1'b0;
    end else begin
      if (step_i) begin
        addr_o  <= addr_o + STEP;
        first_o <= 1'b0;
      end
      if (abort_i) abort_seen_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cp_seq.sv
module cp_seq
  import cp_seq_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          DW      = 32,
  parameter int unsigned MEM_TOP = 'hF000,
  parameter int unsigned VEC_TOP = 'h0020
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wb_i,
  input  logic [DW-1:0] src_i,
  input  logic          int_pend_i,
  input  logic [1:0]    cp_resp_i,
  input  logic [DW-1:0] cp_rdata_i,
  output logic [2:0]    cp_phase_o,
  output logic [DW-1:0] cp_wdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_abort_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          undef_o,
  output logic          cp_abort_o,
  output logic          data_abort_o,
  output logic          intr_o,
  output logic          wb_o,
  output logic [DW-1:0] rd_data_o
);
  localparam logic [DW-1:0] FLAG_VAL = {{4{1'b1}}, {(DW-4){1'b0}}};

  seq_st_e       state_q;
  cp_op_e        op_q;
  cp_rsp_e       rsp;
  logic          wb_q, first_q;
  logic [DW-1:0] src_q;
  logic          is_mem_in, is_mem_q, addr_bad;
  logic          b_load, b_step, b_abort, b_first, b_abort_seen;
  logic [AW-1:0] b_addr;

  assign rsp       = cp_rsp_e'(cp_resp_i);
  assign is_mem_in = (op_i == OP_LD) || (op_i == OP_ST);
  assign is_mem_q  = (op_q == OP_LD) || (op_q == OP_ST);

  cp_addr_chk #(.AW(AW), .MEM_TOP(MEM_TOP), .VEC_TOP(VEC_TOP)) u_addr_chk (
    .addr_i     (addr_i),
    .is_store_i (op_i == OP_ST),
    .bad_o      (addr_bad)
  );

  assign b_load  = (state_q == S_IDLE) && start_i;
  assign b_step  = (state_q == S_BURST) && (rsp == RSP_INC);
  assign b_abort = (state_q == S_BURST) && mem_abort_i;

  cp_burst_unit #(.AW(AW)) u_burst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (b_load),
    .base_i       (addr_i),
    .step_i       (b_step),
    .abort_i      (b_abort),
    .addr_o       (b_addr),
    .first_o      (b_first),
    .abort_seen_o (b_abort_seen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      op_q         <= OP_WR;
      wb_q         <= 1'b0;
      first_q      <= 1'b0;
      src_q        <= '0;
      rd_data_o    <= '0;
      undef_o      <= 1'b0;
      cp_abort_o   <= 1'b0;
      data_abort_o <= 1'b0;
      intr_o       <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          op_q         <= cp_op_e'(op_i);
          wb_q         <= wb_i;
          src_q        <= src_i;
          first_q      <= 1'b1;
          undef_o      <= 1'b0;
          cp_abort_o   <= 1'b0;
          intr_o       <= 1'b0;
          data_abort_o <= is_mem_in && addr_bad;
          state_q      <= (is_mem_in && addr_bad) ? S_FIN : S_ASK;
        end
        S_ASK: begin
          first_q <= 1'b0;
          unique case (rsp)
            RSP_BUSY:   state_q <= S_IWAIT;
            RSP_REFUSE: begin
              if (is_mem_q) cp_abort_o <= 1'b1;
              else          undef_o    <= 1'b1;
              if (op_q == OP_RD) rd_data_o <= FLAG_VAL;
              state_q <= S_FIN;
            end
            default: begin
              if (is_mem_q)             state_q <= S_BURST;
              else if (op_q == OP_DP)   state_q <= S_FIN;
              else                      state_q <= S_CXFER;
            end
          endcase
        end
        S_IWAIT: state_q <= int_pend_i ? S_INTR : S_ASK;
        S_INTR: begin
          intr_o  <= 1'b1;
          state_q <= S_FIN;
        end
        S_CXFER: begin
          if (op_q == OP_RD) begin
            rd_data_o <= cp_rdata_i;
            state_q   <= S_ICYC;
          end else begin
            state_q <= S_FIN;
          end
        end
        S_ICYC: state_q <= S_FIN;
        S_BURST: if (rsp != RSP_INC) begin
          data_abort_o <= b_abort_seen || mem_abort_i;
          state_q      <= S_FIN;
        end
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      S_ASK:   cp_phase_o = first_q ? PH_FIRST : PH_BUSY;
      S_INTR:  cp_phase_o = PH_INTR;
      S_CXFER: cp_phase_o = PH_XFER;
      S_BURST: cp_phase_o = PH_DATA;
      default: cp_phase_o = PH_IDLE;
    endcase
  end

  assign mem_req_o   = (state_q == S_BURST);
  assign mem_we_o    = mem_req_o && (op_q == OP_ST);
  assign mem_addr_o  = b_addr;
  assign mem_wdata_o = cp_rdata_i;
  assign cp_wdata_o  = (mem_req_o && (op_q == OP_LD)) ? mem_rdata_i : src_q;
  assign wb_o        = mem_req_o && b_first && wb_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);

  // Interrupt notice only after an idle cycle that saw a pending interrupt
  assert_intr_after_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_phase_o == PH_INTR) |-> ($past(int_pend_i) && $past(cp_phase_o) == PH_IDLE));

  assert_poll_after_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_phase_o == PH_BUSY) |-> ($past(cp_phase_o) == PH_IDLE && !$past(int_pend_i)));

  assert_addr_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(4)));

  // R5, R6, R9, R12: at most one outcome per instruction
  assert_one_outcome_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot0({undef_o, cp_abort_o, data_abort_o, intr_o}));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_wb_first_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> (mem_req_o && !$past(mem_req_o)));
endmodule

// File: tb/cp_seq_tb.sv
module cp_seq_tb;
  localparam int RSP_BUSY = 0, RSP_REFUSE = 1, RSP_DONE = 2, RSP_INC = 3;
  localparam int NONE = 99;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] addr_i = '0;
  logic        wb_i = 1'b0;
  logic [31:0] src_i = '0;
  logic        int_pend_i = 1'b0;
  logic [1:0]  cp_resp_i = 2'd2;
  logic [31:0] cp_rdata_i = '0;
  logic [2:0]  cp_phase_o;
  logic [31:0] cp_wdata_o;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_abort_i = 1'b0;
  logic        busy_o, done_o, undef_o, cp_abort_o, data_abort_o, intr_o, wb_o;
  logic [31:0] rd_data_o;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  cp_seq u_dut (
    .clk_i, .rst_ni, .start_i, .op_i, .addr_i, .wb_i, .src_i, .int_pend_i,
    .cp_resp_i, .cp_rdata_i, .cp_phase_o, .cp_wdata_o, .mem_req_o, .mem_we_o,
    .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_abort_i, .busy_o, .done_o,
    .undef_o, .cp_abort_o, .data_abort_o, .intr_o, .wb_o, .rd_data_o
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return {a, ~a};
  endfunction

  task automatic run_op(input int op, input int a, input bit wb, input int nb,
                        input int fin, input int int_at, input int nw, input int ab_at);
    int c = 0, busy_seen = 0, words = 0, intr_seen = 0, asks = 0, exp_l;
    bit fin_seen = 0;
    bit mem_op = (op >= 3);
    logic [31:0] srcv = 32'h5A00_0000 ^ (op << 8) ^ nb;
    logic [31:0] rdval = 32'h1234_0000 + nb * 16 + op;
    logic [15:0] base = a[15:0];
    bit bad_addr = mem_op && ((base >= 16'hF000) || (op == 4 && base < 16'h0020));
    bit do_int = (int_at <= nb);
    @(negedge clk_i);
    start_i = 1; op_i = op[2:0]; addr_i = base; wb_i = wb; src_i = srcv;
    @(negedge clk_i);
    start_i = 0;
    while (!fin_seen && c < 80) begin
      c++;
      cp_resp_i = RSP_DONE[1:0]; mem_abort_i = 0;
      int_pend_i = (busy_seen >= int_at);
      case (cp_phase_o)
        3'd1, 3'd2: begin
          chk(cp_phase_o == ((busy_seen == 0) ? 3'd1 : 3'd2), "R2/R3 poll phase",
              cp_phase_o, (busy_seen == 0) ? 1 : 2);
          asks++;
          if (busy_seen < nb) begin cp_resp_i = RSP_BUSY[1:0]; busy_seen++; end
          else cp_resp_i = fin[1:0];
        end
        3'd3: intr_seen++;
        3'd4: begin
          cp_rdata_i = rdval;
          #1;
          if (op == 0) chk(cp_wdata_o == srcv, "R8 write data", cp_wdata_o, srcv);
        end
        3'd5: begin
          logic [15:0] ea = base + 16'(4 * words);
          cp_resp_i = (words < nw - 1) ? RSP_INC[1:0] : RSP_DONE[1:0];
          mem_abort_i = (words == ab_at);
          if (op == 3) mem_rdata_i = mem_word(ea);
          else cp_rdata_i = 32'hC0DE_0000 | words;
          #1;
          chk(mem_req_o && mem_addr_o == ea, "R10 burst address", mem_addr_o, ea);
          chk(mem_we_o == (op == 4), "R10 write enable", mem_we_o, op == 4);
          if (op == 3) chk(cp_wdata_o == mem_word(ea), "R10 load forward", cp_wdata_o, mem_word(ea));
          else chk(mem_wdata_o == (32'hC0DE_0000 | words), "R10 store data", mem_wdata_o,
                   32'hC0DE_0000 | words);
          chk(wb_o == (wb && words == 0), "R11 writeback pulse", wb_o, wb && words == 0);
          words++;
        end
        default: ;
      endcase
      #1;
      if (done_o) fin_seen = 1;
      else @(negedge clk_i);
    end
    chk(fin_seen, "R8 done reached", fin_seen, 1);
    if (bad_addr) begin
      chk(c == 1, "R9 early end", c, 1);
      chk(asks == 0, "R9 no request", asks, 0);
      chk({undef_o, cp_abort_o, data_abort_o, intr_o} == 4'b0010, "R9 flags",
          {undef_o, cp_abort_o, data_abort_o, intr_o}, 4'b0010);
    end else if (do_int) begin
      exp_l = 2 * int_at + 2;
      chk(c == exp_l, "R4 interrupt latency", c, exp_l);
      chk(intr_seen == 1 && words == 0, "R4 notice once, no transfer", intr_seen, 1);
      chk({undef_o, cp_abort_o, data_abort_o, intr_o} == 4'b0001, "R4 flags",
          {undef_o, cp_abort_o, data_abort_o, intr_o}, 4'b0001);
    end else if (fin == RSP_REFUSE) begin
      exp_l = 2 + 2 * nb;
      chk(c == exp_l, "R3 refuse latency", c, exp_l);
      if (mem_op) chk({undef_o, cp_abort_o, data_abort_o, intr_o} == 4'b0100, "R6 cp abort",
                      {undef_o, cp_abort_o, data_abort_o, intr_o}, 4'b0100);
      else chk({undef_o, cp_abort_o, data_abort_o, intr_o} == 4'b1000, "R5 undef trap",
               {undef_o, cp_abort_o, data_abort_o, intr_o}, 4'b1000);
      if (op == 1) chk(rd_data_o == 32'hF000_0000, "R7 flag-only result", rd_data_o, 32'hF000_0000);
    end else begin
      case (op)
        0: exp_l = 3 + 2 * nb;
        1: exp_l = 4 + 2 * nb;
        2: exp_l = 2 + 2 * nb;
        default: exp_l = 2 + 2 * nb + nw;
      endcase
      chk(c == exp_l, "R3/R8/R10 accept latency", c, exp_l);
      if (op == 1) chk(rd_data_o == rdval, "R8 read result", rd_data_o, rdval);
      if (mem_op) begin
        chk(words == nw, "R10 burst length", words, nw);
        chk(data_abort_o == (ab_at < nw), "R12 memory abort", data_abort_o, ab_at < nw);
      end
      chk(!undef_o && !cp_abort_o && !intr_o, "R5/R6 no trap", {undef_o, cp_abort_o, intr_o}, 0);
    end
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R8 single done pulse", {done_o, busy_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !wb_o && !mem_req_o && cp_phase_o == 0, "R1 reset outputs",
        {busy_o, done_o, wb_o, mem_req_o, cp_phase_o}, 0);
    chk({undef_o, cp_abort_o, data_abort_o, intr_o} == 0, "R1 reset flags",
        {undef_o, cp_abort_o, data_abort_o, intr_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    for (int op = 0; op < 5; op++)
      for (int nb = 0; nb < 4; nb++)
        for (int f = 1; f < 3; f++)
          run_op(op, 'h0100, 0, nb, f, NONE, (op >= 3) ? 2 : 1, NONE);
    for (int op = 0; op < 5; op++)
      for (int nb = 1; nb < 4; nb++)
        for (int k = 1; k <= nb; k++)
          run_op(op, 'h0200, 1, nb, RSP_DONE, k, 2, NONE);
    for (int op = 3; op < 5; op++)
      for (int nw = 1; nw < 5; nw++)
        for (int wb = 0; wb < 2; wb++) begin
          run_op(op, 'h0400, wb[0], 1, RSP_DONE, NONE, nw, NONE);
          run_op(op, 'h0400, wb[0], 0, RSP_INC, NONE, nw, 0);
          run_op(op, 'h0400, wb[0], 1, RSP_DONE, NONE, nw, nw - 1);
        end
    run_op(3, 'hF000, 0, 0, RSP_DONE, NONE, 1, NONE);
    run_op(4, 'hFFFC, 0, 0, RSP_DONE, NONE, 1, NONE);
    run_op(4, 'h0010, 0, 0, RSP_DONE, NONE, 1, NONE);
    run_op(3, 'h0010, 0, 0, RSP_DONE, NONE, 1, NONE);
    run_op(4, 'h0020, 0, 0, RSP_DONE, NONE, 1, NONE);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule